// File: doc/BRIEF.md
# Dirty-Line Write-Drain Controller

This block decides when dirty lines held in a large memory-side buffer cache are written back to DRAM. Every write that reaches the buffer cache is installed there at once, hit or miss, so the write retires without waiting for DRAM. The controller keeps a dirty flag, a queued flag and a rank/page tag for every line. It also keeps a running count of dirty lines. From this state it feeds the DRAM write queue.

A scanner walks the sets and picks dirty lines to hand to the write queue, one line per cycle at most. Once it has chosen a DRAM page on a rank, it keeps choosing lines of that same rank/page for as long as any remain, so the scheduler can open the page once and stream the writes. Outside a burst it tops the write queue up to a fill mark, which leaves the scheduler free to serve reads first. When the dirty count climbs above a programmable high threshold, the block raises a write-burst mode to the scheduler and then fills the queue to its full depth. The mode stays up until the count falls below a separate, lower watermark.

The set and way counts must be powers of two. A line index is the set number concatenated above the way number.

Top module: `write_drain_ctrl`

## Requirements
- R1: An install (`wrValid`) marks the addressed line dirty and records its rank/page. The dirty count rises by one only when the line was clean; a second write to a line that is already dirty leaves the count unchanged.
- R2: The dirty count falls by one for each writeback acknowledge that clears a line. The count never exceeds the number of lines and changes by at most one per cycle. When every line has been written back, the count is zero.
- R3: `writeBurst` (1 = write burst, 0 = reads have priority) rises one cycle after a cycle in which the dirty count is greater than `hiThreshold`.
- R4: Once raised, `writeBurst` stays high until the cycle after a cycle in which the dirty count is below `loWatermark` (hysteresis).
- R5: Each `wqPush` names, through `wqSet`/`wqWay`, a line that is dirty and not already queued. `wqRank`/`wqPage` carry the rank/page last installed for that line.
- R6: `wqPush` is asserted only while `wqOccupancy` is below `WqFillMark` in read-priority mode, or below `WqDepth` in burst mode. With eligible lines present, the queue is topped up to that level.
- R7: A queued line stays dirty until its acknowledge (`ackValid`). If a write hits the line between its push and its acknowledge (or in the same cycle as either), the acknowledge leaves the line dirty, skips the decrement, and makes the line eligible to be pushed again.
- R8: While any eligible line shares the rank/page of the most recently pushed line, every push carries that same rank/page. A new rank/page is chosen only when none remains.
- R9: The scan pointer moves round-robin to the next set that holds an eligible line, one step per cycle, and skips sets with none. While pushes are allowed and an eligible line exists, no more than `NumSets` consecutive cycles pass without a push.
- R10: After reset no line is dirty, `wqPush` is low and `writeBurst` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrValid | input | 1 | A write is installed this cycle |
| wrSet | input | log2(NumSets) | Set of the installed line |
| wrWay | input | log2(NumWays) | Way of the installed line |
| wrRank | input | RankW | DRAM rank of the installed line |
| wrPage | input | PageW | DRAM page of the installed line |
| ackValid | input | 1 | Write queue finished writing back a line |
| ackSet | input | log2(NumSets) | Set of the acknowledged line |
| ackWay | input | log2(NumWays) | Way of the acknowledged line |
| wqOccupancy | input | log2(WqDepth+1) | Entries now held by the DRAM write queue |
| hiThreshold | input | log2(lines+1) | Dirty count above which burst mode starts |
| loWatermark | input | log2(lines+1) | Dirty count below which burst mode ends |
| wqPush | output | 1 | Enqueue one line to the write queue this cycle |
| wqSet | output | log2(NumSets) | Set of the pushed line |
| wqWay | output | log2(NumWays) | Way of the pushed line |
| wqRank | output | RankW | Rank of the pushed line |
| wqPage | output | PageW | Page of the pushed line |
| writeBurst | output | 1 | 1 = write burst, 0 = read priority |

## Verification
The assertions assume the following of the inputs:
- An acknowledge only names a line that was pushed and has not yet been acknowledged.
- A write into a line that is already dirty is a hit, so it carries the same rank/page the line already holds.
- The write queue never reports more entries than it can hold.

The stimulus meets these assumptions by construction. The bench keeps its own write queue and acknowledges only its oldest entry. For a write to a dirty line it reuses the rank/page its model recorded for that line, and it draws a fresh rank/page only for clean lines. It derives `wqOccupancy` from its own queue length, plus a bounded extra amount used to hold pushes back.

// File: rtl/wdc_pkg.sv
package wdc_pkg;

  // Strobes sent from the scan control to the line-state datapath.
  typedef struct packed {
    logic push;      // mark the selected line as queued
    logic retarget;  // latch the selected line's rank/page as the new group
  } scanStrobe_t;

endpackage

// File: rtl/wdc_datapath.sv
module wdc_datapath
  import wdc_pkg::*;
#(
  parameter int NumSets = 8,
  parameter int NumWays = 4,
  parameter int TagW    = 5,
  localparam int SetW   = $clog2(NumSets),
  localparam int WayW   = $clog2(NumWays),
  localparam int LineW  = SetW + WayW,
  localparam int Lines  = NumSets * NumWays,
  localparam int CntW   = $clog2(Lines + 1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrValid,
  input  logic [SetW-1:0]            wrSet,
  input  logic [WayW-1:0]            wrWay,
  input  logic [TagW-1:0]            wrTag,
  input  logic                       ackValid,
  input  logic [SetW-1:0]            ackSet,
  input  logic [WayW-1:0]            ackWay,
  input  scanStrobe_t                strobe,
  input  logic [SetW-1:0]            pushSet,
  input  logic [WayW-1:0]            pushWay,
  output logic [Lines-1:0]           pendingMask,
  output logic [Lines-1:0][TagW-1:0] lineTag,
  output logic [TagW-1:0]            target,
  output logic                       targetValid,
  output logic [CntW-1:0]            dirtyCount,
  output logic [TagW-1:0]            pushTag
);

  logic [LineW-1:0] wrLine, ackLine, pushLine;
  logic [Lines-1:0] dirtyVec, queuedVec, redirtyVec, incVec, decVec;
  logic [CntW-1:0]  countQ;
  logic [TagW-1:0]  targetQ;
  logic             targetValidQ;

  assign wrLine   = {wrSet, wrWay};
  assign ackLine  = {ackSet, ackWay};
  assign pushLine = {pushSet, pushWay};

  for (genvar l = 0; l < Lines; l++) begin : g_line
    logic dirtyQ, queuedQ, redirtyQ;
    logic [TagW-1:0] tagQ;
    logic wrHit, ackHit, pushHit;

    assign wrHit   = wrValid && (wrLine == LineW'(l));
    assign ackHit  = ackValid && (ackLine == LineW'(l));
    assign pushHit = strobe.push && (pushLine == LineW'(l));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dirtyQ   <= 1'b0;
        queuedQ  <= 1'b0;
        redirtyQ <= 1'b0;
        tagQ     <= '0;
      end else begin
        if (wrHit) begin
          dirtyQ <= 1'b1;
          tagQ   <= wrTag;
        end else if (ackHit && !redirtyQ) begin
          dirtyQ <= 1'b0;
        end
        if (pushHit)     queuedQ <= 1'b1;
        else if (ackHit) queuedQ <= 1'b0;
        if (ackHit)                             redirtyQ <= 1'b0;
        else if (wrHit && (queuedQ || pushHit)) redirtyQ <= 1'b1;
      end
    end

    assign dirtyVec[l]    = dirtyQ;
    assign queuedVec[l]   = queuedQ;
    assign redirtyVec[l]  = redirtyQ;
    assign lineTag[l]     = tagQ;
    assign pendingMask[l] = dirtyQ && !queuedQ;
    assign incVec[l]      = wrHit && !dirtyQ;
    assign decVec[l]      = ackHit && !redirtyQ && !wrHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ       <= '0;
      targetQ      <= '0;
      targetValidQ <= 1'b0;
    end else begin
      countQ <= countQ + CntW'(|incVec) - CntW'(|decVec);
      if (strobe.retarget) begin
        targetQ      <= lineTag[pushLine];
        targetValidQ <= 1'b1;
      end
    end
  end

  assign dirtyCount  = countQ;
  assign target      = targetQ;
  assign targetValid = targetValidQ;
  assign pushTag     = lineTag[pushLine];

  // R7: the write queue only acknowledges lines it holds
  assert_ack_queued_R7: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |-> queuedVec[ackLine]);

  // R7: a line rewritten while queued survives its acknowledge as eligible
  assert_redirty_keep_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && redirtyVec[ackLine]) |=>
      (dirtyVec[$past(ackLine)] && !queuedVec[$past(ackLine)]));

  // R5: the scanner only pushes dirty lines that are not queued yet
  assert_push_eligible_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |-> pendingMask[pushLine]);

  // R2: count bounded by the number of lines
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    countQ <= CntW'(Lines));

  // R2: count moves by at most one per cycle
  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (countQ != $past(countQ)) |->
      ((countQ == $past(countQ) + CntW'(1)) || (countQ == $past(countQ) - CntW'(1))));

endmodule

// File: rtl/wdc_control.sv
module wdc_control
  import wdc_pkg::*;
#(
  parameter int NumSets    = 8,
  parameter int NumWays    = 4,
  parameter int TagW       = 5,
  parameter int WqDepth    = 8,
  parameter int WqFillMark = 6,
  localparam int SetW      = $clog2(NumSets),
  localparam int WayW      = $clog2(NumWays),
  localparam int Lines     = NumSets * NumWays,
  localparam int CntW      = $clog2(Lines + 1),
  localparam int OccW      = $clog2(WqDepth + 1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [Lines-1:0]           pendingMask,
  input  logic [Lines-1:0][TagW-1:0] lineTag,
  input  logic [TagW-1:0]            target,
  input  logic                       targetValid,
  input  logic [CntW-1:0]            dirtyCount,
  input  logic [OccW-1:0]            wqOccupancy,
  input  logic [CntW-1:0]            hiThreshold,
  input  logic [CntW-1:0]            loWatermark,
  output scanStrobe_t                strobe,
  output logic [SetW-1:0]            pushSet,
  output logic [WayW-1:0]            pushWay,
  output logic                       writeBurst
);

  logic [SetW-1:0]    scanPtr, nextPtr;
  logic               burstQ, burstNext;
  logic [Lines-1:0]   matchMask;
  logic [NumSets-1:0] setBusy;
  logic [NumWays-1:0] candMask;
  logic [WayW-1:0]    pickWay;
  logic               pickFound, anyMatch, canPush;
  logic [OccW-1:0]    fillLimit;

  for (genvar l = 0; l < Lines; l++) begin : g_match
    assign matchMask[l] = pendingMask[l] && targetValid && (lineTag[l] == target);
  end

  for (genvar s = 0; s < NumSets; s++) begin : g_busy
    assign setBusy[s] = |pendingMask[s*NumWays +: NumWays];
  end

  assign anyMatch = |matchMask;
  assign candMask = anyMatch ? matchMask[int'(scanPtr)*NumWays +: NumWays]
                             : pendingMask[int'(scanPtr)*NumWays +: NumWays];

  // lowest eligible way in the set under the pointer
  always_comb begin
    pickWay   = '0;
    pickFound = 1'b0;
    for (int w = NumWays - 1; w >= 0; w--) begin
      if (candMask[w]) begin
        pickWay   = WayW'(w);
        pickFound = 1'b1;
      end
    end
  end

  // next set after the pointer (circularly) that holds an eligible line
  always_comb begin
    int idx;
    idx     = 0;
    nextPtr = scanPtr;
    for (int k = NumSets; k >= 1; k--) begin
      idx = (int'(scanPtr) + k) % NumSets;
      if (setBusy[idx]) nextPtr = SetW'(idx);
    end
  end

  assign fillLimit = burstQ ? OccW'(WqDepth) : OccW'(WqFillMark);
  assign canPush   = wqOccupancy < fillLimit;

  always_comb begin
    strobe.push     = canPush && pickFound;
    strobe.retarget = canPush && pickFound && !anyMatch;
  end

  always_comb begin
    burstNext = burstQ;
    if (!burstQ && (dirtyCount > hiThreshold))     burstNext = 1'b1;
    else if (burstQ && (dirtyCount < loWatermark)) burstNext = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scanPtr <= '0;
      burstQ  <= 1'b0;
    end else begin
      scanPtr <= nextPtr;
      burstQ  <= burstNext;
    end
  end

  assign pushSet    = scanPtr;
  assign pushWay    = pickWay;
  assign writeBurst = burstQ;

  // R6: never push into a full write queue
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |-> (wqOccupancy < OccW'(WqDepth)));

  // R3: burst mode starts only after the count exceeded the high threshold
  assert_burst_enter_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(burstQ) |-> ($past(dirtyCount) > $past(hiThreshold)));

  // R4: burst mode ends only after the count fell under the low watermark
  assert_burst_exit_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(burstQ) |-> ($past(dirtyCount) < $past(loWatermark)));

endmodule

// File: rtl/write_drain_ctrl.sv
module write_drain_ctrl
  import wdc_pkg::*;
#(
  parameter int NumSets    = 8,
  parameter int NumWays    = 4,
  parameter int RankW      = 2,
  parameter int PageW      = 3,
  parameter int WqDepth    = 8,
  parameter int WqFillMark = 6,
  localparam int TagW      = RankW + PageW,
  localparam int SetW      = $clog2(NumSets),
  localparam int WayW      = $clog2(NumWays),
  localparam int CntW      = $clog2(NumSets * NumWays + 1),
  localparam int OccW      = $clog2(WqDepth + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrValid,
  input  logic [SetW-1:0] wrSet,
  input  logic [WayW-1:0] wrWay,
  input  logic [RankW-1:0] wrRank,
  input  logic [PageW-1:0] wrPage,
  input  logic            ackValid,
  input  logic [SetW-1:0] ackSet,
  input  logic [WayW-1:0] ackWay,
  input  logic [OccW-1:0] wqOccupancy,
  input  logic [CntW-1:0] hiThreshold,
  input  logic [CntW-1:0] loWatermark,
  output logic            wqPush,
  output logic [SetW-1:0] wqSet,
  output logic [WayW-1:0] wqWay,
  output logic [RankW-1:0] wqRank,
  output logic [PageW-1:0] wqPage,
  output logic            writeBurst
);

  localparam int Lines = NumSets * NumWays;

  scanStrobe_t                strobe;
  logic [Lines-1:0]           pendingMask;
  logic [Lines-1:0][TagW-1:0] lineTag;
  logic [TagW-1:0]            target, pushTag;
  logic                       targetValid;
  logic [CntW-1:0]            dirtyCount;
  logic [SetW-1:0]            pushSet;
  logic [WayW-1:0]            pushWay;

  wdc_datapath #(.NumSets(NumSets), .NumWays(NumWays), .TagW(TagW)) u_datapath (
    .clk(clk), .rstN(rstN),
    .wrValid(wrValid), .wrSet(wrSet), .wrWay(wrWay), .wrTag({wrRank, wrPage}),
    .ackValid(ackValid), .ackSet(ackSet), .ackWay(ackWay),
    .strobe(strobe), .pushSet(pushSet), .pushWay(pushWay),
    .pendingMask(pendingMask), .lineTag(lineTag),
    .target(target), .targetValid(targetValid),
    .dirtyCount(dirtyCount), .pushTag(pushTag)
  );

  wdc_control #(.NumSets(NumSets), .NumWays(NumWays), .TagW(TagW),
                .WqDepth(WqDepth), .WqFillMark(WqFillMark)) u_control (
    .clk(clk), .rstN(rstN),
    .pendingMask(pendingMask), .lineTag(lineTag),
    .target(target), .targetValid(targetValid),
    .dirtyCount(dirtyCount), .wqOccupancy(wqOccupancy),
    .hiThreshold(hiThreshold), .loWatermark(loWatermark),
    .strobe(strobe), .pushSet(pushSet), .pushWay(pushWay),
    .writeBurst(writeBurst)
  );

  assign wqPush = strobe.push;
  assign wqSet  = pushSet;
  assign wqWay  = pushWay;
  assign wqRank = pushTag[TagW-1:PageW];
  assign wqPage = pushTag[PageW-1:0];

endmodule

// File: tb/tb_write_drain_ctrl.sv
`timescale 1ns/1ps
module tb_write_drain_ctrl;
  localparam int NumSets = 8, NumWays = 4, RankW = 2, PageW = 3;
  localparam int WqDepth = 8, WqFillMark = 6;
  localparam int Lines = NumSets * NumWays;

  logic clk = 1'b0, rstN = 1'b0;
  logic wrValid = 1'b0, ackValid = 1'b0;
  logic [2:0] wrSet = '0, ackSet = '0;
  logic [1:0] wrWay = '0, ackWay = '0;
  logic [RankW-1:0] wrRank = '0;
  logic [PageW-1:0] wrPage = '0;
  logic [3:0] wqOccupancy = '0;
  logic [5:0] hiThreshold = '0, loWatermark = '0;
  logic wqPush, writeBurst;
  logic [2:0] wqSet;
  logic [1:0] wqWay;
  logic [RankW-1:0] wqRank;
  logic [PageW-1:0] wqPage;

  always #2 clk = ~clk;

  write_drain_ctrl #(.NumSets(NumSets), .NumWays(NumWays), .RankW(RankW), .PageW(PageW),
                     .WqDepth(WqDepth), .WqFillMark(WqFillMark)) dut (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrSet(wrSet), .wrWay(wrWay),
    .wrRank(wrRank), .wrPage(wrPage), .ackValid(ackValid), .ackSet(ackSet), .ackWay(ackWay),
    .wqOccupancy(wqOccupancy), .hiThreshold(hiThreshold), .loWatermark(loWatermark),
    .wqPush(wqPush), .wqSet(wqSet), .wqWay(wqWay), .wqRank(wqRank), .wqPage(wqPage),
    .writeBurst(writeBurst)
  );

  int nChecks = 0, nFails = 0;
  bit mDirty[Lines], mQueued[Lines], mRedirty[Lines], seenPush[Lines];
  int mTag[Lines];
  int mCount = 0, lastTag = 0, occExtra = 0, stall = 0, hiT = 0, loT = 0;
  bit mBurst = 1'b0, lastValid = 1'b0;
  int q[$];

  task automatic chk(bit ok, string req, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit tagPending(int tag);
    for (int l = 0; l < Lines; l++)
      if (mDirty[l] && !mQueued[l] && mTag[l] == tag) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit anyPending();
    for (int l = 0; l < Lines; l++)
      if (mDirty[l] && !mQueued[l]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int randTag();
    return ($urandom_range(1, 0) << PageW) | $urandom_range(3, 0);
  endfunction

  task automatic step(bit doWr, int line, int tag, bit doAck);
    int occ, ackLine, pl, limit, ptag;
    bit allowed, pushed, inc, dec, preRed, nb;
    @(negedge clk);
    occ = q.size() + occExtra;
    if (occ > WqDepth) occ = WqDepth;
    wrValid = doWr;
    wrSet = 3'(line / NumWays);
    wrWay = 2'(line % NumWays);
    wrRank = RankW'(tag >> PageW);
    wrPage = PageW'(tag);
    ackLine = -1;
    if (doAck && q.size() > 0) begin
      ackLine = q[0];
      ackSet = 3'(ackLine / NumWays);
      ackWay = 2'(ackLine % NumWays);
    end
    ackValid = (ackLine >= 0);
    wqOccupancy = 4'(occ);
    hiThreshold = 6'(hiT);
    loWatermark = 6'(loT);
    #1;
    chk(writeBurst == mBurst, "R3 R4 mode", int'(writeBurst), int'(mBurst));
    limit = mBurst ? WqDepth : WqFillMark;
    allowed = occ < limit;
    pushed = wqPush;
    pl = int'(wqSet) * NumWays + int'(wqWay);
    if (pushed) begin
      ptag = int'({wqRank, wqPage});
      chk(mDirty[pl] && !mQueued[pl], "R5 eligible line", int'(mDirty[pl]) * 2 + int'(mQueued[pl]), 2);
      chk(ptag == mTag[pl], "R5 rank/page", ptag, mTag[pl]);
      chk(allowed, "R6 fill limit", occ, limit);
      if (lastValid && tagPending(lastTag)) chk(ptag == lastTag, "R8 page group", ptag, lastTag);
      seenPush[pl] = 1'b1;
    end
    if (anyPending() && allowed && !pushed) stall++;
    else stall = 0;
    chk(stall <= NumSets, "R9 scan progress", stall, NumSets);
    // model update for the coming edge
    inc = doWr && !mDirty[line];
    preRed = (ackLine >= 0) ? mRedirty[ackLine] : 1'b0;
    dec = (ackLine >= 0) && !preRed && !(doWr && line == ackLine);
    nb = mBurst;
    if (!mBurst && mCount > hiT) nb = 1'b1;
    else if (mBurst && mCount < loT) nb = 1'b0;
    mBurst = nb;
    if (ackLine >= 0) begin
      if (dec) mDirty[ackLine] = 1'b0;
      mQueued[ackLine] = 1'b0;
      mRedirty[ackLine] = 1'b0;
      void'(q.pop_front());
    end
    if (doWr) begin
      if (ackLine != line && (mQueued[line] || (pushed && pl == line))) mRedirty[line] = 1'b1;
      mDirty[line] = 1'b1;
      mTag[line] = tag;
    end
    if (pushed) begin
      mQueued[pl] = 1'b1;
      lastTag = mTag[pl];
      lastValid = 1'b1;
      q.push_back(pl);
    end
    mCount = mCount + int'(inc) - int'(dec);
  endtask

  task automatic idle(int n, bit doAck);
    for (int i = 0; i < n; i++) step(1'b0, 0, 0, doAck);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 200000, 0);
    report();
  end

  initial begin
    int qline, ql;
    void'($urandom(32'h5eed1234));
    for (int l = 0; l < Lines; l++) begin
      mDirty[l] = 0; mQueued[l] = 0; mRedirty[l] = 0; mTag[l] = 0; seenPush[l] = 0;
    end
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    chk(wqPush == 1'b0, "R10 reset push", int'(wqPush), 0);
    chk(writeBurst == 1'b0, "R10 reset mode", int'(writeBurst), 0);

    // R1: a hit on a dirty line is not counted twice
    hiT = 1; loT = 0; occExtra = WqDepth;
    step(1'b1, 0, 5, 1'b0);
    step(1'b1, 0, 5, 1'b0);
    idle(2, 1'b0);
    chk(writeBurst == 1'b0, "R1 rewrite counted once", int'(writeBurst), 0);
    step(1'b1, 1, 5, 1'b0);
    idle(2, 1'b0);
    chk(writeBurst == 1'b1, "R3 enter above threshold", int'(writeBurst), 1);

    // R8 grouping and R6 top-up
    step(1'b1, 9, 2, 1'b0);
    step(1'b1, 17, 6, 1'b0);
    step(1'b1, 20, 2, 1'b0);
    step(1'b1, 30, 6, 1'b0);
    step(1'b1, 3, 2, 1'b0);
    hiT = 30; loT = 31; occExtra = 0;
    idle(20, 1'b0);
    chk(q.size() >= WqFillMark, "R6 queue topped up", q.size(), WqFillMark);
    chk(writeBurst == 1'b0, "R4 exit below watermark", int'(writeBurst), 0);

    // R7: rewrite a queued line, then acknowledge it
    qline = q[0];
    step(1'b1, qline, mTag[qline], 1'b0);
    step(1'b0, 0, 0, 1'b1);
    seenPush[qline] = 1'b0;
    idle(14, 1'b1);
    chk(seenPush[qline], "R7 rewritten line pushed again", int'(seenPush[qline]), 1);

    // R7: rewrite on the same cycle as the acknowledge
    if (q.size() > 0) begin
      ql = q[0];
      step(1'b1, ql, mTag[ql], 1'b1);
      seenPush[ql] = 1'b0;
      idle(14, 1'b1);
      chk(seenPush[ql], "R7 same-cycle rewrite kept", int'(seenPush[ql]), 1);
    end

    // constrained random traffic
    for (int i = 0; i < 6000; i++) begin
      int line, tag;
      if (i % 600 == 0) begin
        hiT = $urandom_range(20, 3);
        loT = $urandom_range(hiT, 0);
      end
      if ($urandom_range(9, 0) == 0) occExtra = $urandom_range(4, 0);
      line = $urandom_range(Lines - 1, 0);
      tag = mDirty[line] ? mTag[line] : randTag();
      step($urandom_range(1, 0) == 1, line, tag, $urandom_range(99, 0) < 40);
    end

    // R2: drain everything; count back to zero ends burst with watermark 1
    occExtra = 0; hiT = 0; loT = 1;
    idle(300, 1'b1);
    chk(mCount == 0, "R2 model drained", mCount, 0);
    chk(writeBurst == 1'b0, "R2 count returns to zero", int'(writeBurst), 0);
    chk(wqPush == 1'b0, "R2 nothing left to push", int'(wqPush), 0);
    report();
  end
endmodule